// File: doc/BRIEF.md
# Glitch-Capture Delay Signature Array

This block builds a 64-bit device signature from an array of delay-race bit cells. Each cell runs two 16-bit rotating shift registers on one clock. They are loaded with complementary alternating patterns, so their serial outputs are always opposite. A pair of 2:1 multiplexers combines the two outputs so that the result is 0 whenever both paths switch together. When one path switches later than the other, the result shows a short positive spike. A spike that is wide enough sets a self-holding capture flop, and that flop then keeps the bit at 1 until the next measurement.

Real fabrication variation cannot be synthesized. Each cell therefore carries a skew value, in sub-cycle units, that stands in for the delay difference between its two paths. The skew values come from a fixed formula of the cell index and a seed parameter. On every shift, the cell compares its skew with a minimum pulse width, which stands in for the filtering of narrow spikes along the route to the preset pin. A measurement starts after a synchronous reset. It runs for 32 enabled cycles and then freezes. Software or a test harness then reads the signature one byte at a time through a byte selector, starting at the highest byte.

Top module: `glitch_puf_array`

## Requirements
- R1: In every cell, shift register A is loaded with 0x5555 and B with 0xAAAA. Both rotate left on each shift and present their MSB, so A's output starts at 0 and the two outputs are always complementary.
- R2: When a shift makes A's output rise and the cell skew is at least MIN_PULSE (B path slower), the cell's bit becomes 1 at that clock edge.
- R3: When a shift makes A's output fall and the negated skew is at least MIN_PULSE (A path slower), the cell's bit becomes 1 at that clock edge.
- R4: A cell whose skew magnitude is below MIN_PULSE, including a skew of zero, keeps its bit at 0 for the whole measurement.
- R5: Shifting, and with it any capture, happens only in cycles where en is high and done is low.
- R6: Once a bit is 1, it stays 1 until reset.
- R7: Cell i has skew ((37*i + SKEW_SEED) mod SKEW_SPAN) - SKEW_SPAN/2, with integer division. Bit i of the signature is cell i.
- R8: done goes high at the clock edge of the 32nd enabled cycle, stays high, and from then on the signature no longer changes.
- R9: A byte_sel value k from 0 to 7 puts signature bits [8k+7:8k] on sig_byte. Any byte_sel value of 8 or more gives 0.
- R10: A synchronous reset clears every bit, the cycle count and done, and reloads both register seeds. Reset takes priority over en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run the measurement while high |
| byte_sel | input | 8 | Signature byte to show |
| sig_byte | output | 8 | Selected signature byte |
| done | output | 1 | Measurement complete, signature frozen |

## Verification
Two events can fall in the same clock edge. First, the 32nd enabled shift, which may carry a capture, coincides with done rising. The bench holds en high across that edge and well beyond it. It judges the result by done rising exactly on the 32nd enabled cycle and by the signature staying unchanged over the following ten enabled cycles. Second, reset can meet an active enable. The bench asserts reset while en is high and expects a cleared signature and done. It then expects a rerun to rebuild the same signature.

// File: rtl/gp_pkg.sv
package gp_pkg;
  // Alternating pattern with bit 0 set: 0x5555 for a 16-bit width.
  function automatic logic [63:0] alt_seed(input int width);
    logic [63:0] v;
    v = '0;
    for (int j = 0; j < 64; j++) begin
      if (j < width) v[j] = (j % 2 == 0);
    end
    return v;
  endfunction

  // Stand-in for fabrication skew, in sub-cycle units.
  function automatic int cell_skew(input int idx, input int seed, input int span);
    return ((idx * 37 + seed) % span) - (span / 2);
  endfunction
endpackage

// File: rtl/gp_circ_shreg.sv
module gp_circ_shreg #(
  parameter int W = 16,
  parameter logic [W-1:0] SEED = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic shift,
  output logic q_msb
);
  logic [W-1:0] r;

  always_ff @(posedge clk) begin
    if (rst) r <= SEED;
    else if (shift) r <= {r[W-2:0], r[W-1]};
  end

  assign q_msb = r[W-1];
endmodule

// File: rtl/gp_race_cell.sv
module gp_race_cell #(
  parameter int SR_W      = 16,
  parameter int SKEW      = 0,
  parameter int MIN_PULSE = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic shift,
  output logic a_out,
  output logic b_out,
  output logic bit_q
);
  localparam logic [SR_W-1:0] SEED_A = SR_W'(gp_pkg::alt_seed(SR_W));
  localparam logic [SR_W-1:0] SEED_B = ~SEED_A;
  // Spike on A rising edge: B path slower; on A falling edge: A path slower.
  localparam logic RISE_HIT = (SKEW >= MIN_PULSE);
  localparam logic FALL_HIT = (-SKEW >= MIN_PULSE);

  logic spike;

  gp_circ_shreg #(.W(SR_W), .SEED(SEED_A)) u_a (
    .clk(clk), .rst(rst), .shift(shift), .q_msb(a_out));
  gp_circ_shreg #(.W(SR_W), .SEED(SEED_B)) u_b (
    .clk(clk), .rst(rst), .shift(shift), .q_msb(b_out));

  // Race model: a transition this edge leaves a spike when the skew is wide enough.
  always_comb begin
    spike = 1'b0;
    if (shift) spike = a_out ? FALL_HIT : RISE_HIT;
  end

  // Self-holding capture flop: Q fed back, spike acts as preset.
  always_ff @(posedge clk) begin
    if (rst) bit_q <= 1'b0;
    else if (spike) bit_q <= 1'b1;
    else bit_q <= bit_q;
  end
endmodule

// File: rtl/gp_settle_ctl.sv
module gp_settle_ctl #(
  parameter int SETTLE = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic shift,
  output logic done
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic [CW-1:0] cnt;

  assign shift = en && !done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (shift) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) done <= 1'b1;
    end
  end
endmodule

// File: rtl/gp_byte_view.sv
module gp_byte_view #(
  parameter int N_BYTES = 8,
  parameter int BYTE_W  = 8,
  parameter int SEL_W   = 8
) (
  input  logic [N_BYTES*BYTE_W-1:0] sig,
  input  logic [SEL_W-1:0]          sel,
  output logic [BYTE_W-1:0]         dout
);
  always_comb begin
    dout = '0;
    for (int k = 0; k < N_BYTES; k++) begin
      if (sel == SEL_W'(k)) dout = sig[k*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/glitch_puf_array.sv
module glitch_puf_array #(
  parameter int N_BYTES   = 8,
  parameter int BYTE_W    = 8,
  parameter int SR_W      = 16,
  parameter int SETTLE    = 32,
  parameter int MIN_PULSE = 2,
  parameter int SKEW_SEED = 3,
  parameter int SKEW_SPAN = 15
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [7:0]  byte_sel,
  output logic [7:0]  sig_byte,
  output logic        done
);
  localparam int SIG_W = N_BYTES * BYTE_W;

  logic             shift;
  logic [SIG_W-1:0] sig_all;
  logic [SIG_W-1:0] a_all;
  logic [SIG_W-1:0] b_all;

  gp_settle_ctl #(.SETTLE(SETTLE)) u_ctl (
    .clk(clk), .rst(rst), .en(en), .shift(shift), .done(done));

  for (genvar i = 0; i < SIG_W; i++) begin : g_cell
    localparam int SK = gp_pkg::cell_skew(i, SKEW_SEED, SKEW_SPAN);
    gp_race_cell #(.SR_W(SR_W), .SKEW(SK), .MIN_PULSE(MIN_PULSE)) u_cell (
      .clk(clk), .rst(rst), .shift(shift),
      .a_out(a_all[i]), .b_out(b_all[i]), .bit_q(sig_all[i]));
  end

  gp_byte_view #(.N_BYTES(N_BYTES), .BYTE_W(BYTE_W), .SEL_W(8)) u_view (
    .sig(sig_all), .sel(byte_sel), .dout(sig_byte));
endmodule

// File: rtl/glitch_puf_checker.sv
module glitch_puf_checker #(
  parameter int SIG_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             done,
  input logic [SIG_W-1:0] sig,
  input logic [SIG_W-1:0] a_vec,
  input logic [SIG_W-1:0] b_vec
);
  assert_complement_R1: assert property (@(posedge clk) disable iff (rst)
    a_vec == ~b_vec);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!en || done) |=> $stable(a_vec));

  assert_sticky_bits_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((sig & $past(sig)) == $past(sig)));

  assert_done_holds_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_frozen_sig_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(sig));
endmodule

bind glitch_puf_array glitch_puf_checker #(.SIG_W(SIG_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .done(done),
  .sig(sig_all), .a_vec(a_all), .b_vec(b_all));

// File: tb/glitch_puf_array_test.sv
module glitch_puf_array_test;
  localparam int SEED = 3;
  localparam int SPAN = 15;
  localparam int MINP = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [7:0] byte_sel = 8'd0;
  logic [7:0] sig_byte;
  logic       done;

  int total = 0;
  int bad = 0;
  logic [63:0] exp_first;
  logic [63:0] exp_full;

  glitch_puf_array uut (
    .clk(clk), .rst(rst), .en(en), .byte_sel(byte_sel),
    .sig_byte(sig_byte), .done(done));

  always #10 clk = ~clk;

  function automatic int skew_of(input int i);
    return ((37 * i + SEED) % SPAN) - (SPAN / 2);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_sig(input string req, input logic [63:0] exp);
    for (int k = 0; k < 8; k++) begin
      byte_sel = 8'(7 - k);  // highest byte first
      #1;
      chk(req, {56'd0, sig_byte}, {56'd0, exp[(7-k)*8 +: 8]});
    end
  endtask

  task automatic run_cycles(input int n, input logic e);
    for (int c = 0; c < n; c++) begin
      en = e;
      @(negedge clk);
    end
    en = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      exp_first[i] = (skew_of(i) >= MINP);
      exp_full[i]  = (skew_of(i) >= MINP) || (-skew_of(i) >= MINP);
    end
    // R4: the formula yields zero-skew cells (e.g. 7) that must stay 0
    if (skew_of(7) != 0) $display("note: cell 7 skew %0d", skew_of(7));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10 done after reset", {63'd0, done}, 64'd0);
    check_sig("R10 reset signature", 64'd0);

    // One enabled edge: A rises, only positive-skew cells fire (R2, R7)
    run_cycles(1, 1'b1);
    check_sig("R2 first shift captures", exp_first);

    // Idle: no shift, so negative-skew cells must not fire yet (R5, R3)
    run_cycles(5, 1'b0);
    check_sig("R5 idle no capture", exp_first);
    chk("R5 no done while idle", {63'd0, done}, 64'd0);

    // Second enabled edge: A falls, negative-skew cells fire (R3)
    run_cycles(1, 1'b1);
    check_sig("R3 second shift captures", exp_full);

    // Up to 31 enabled cycles: done still low
    run_cycles(29, 1'b1);
    #1;
    chk("R8 done low at 31", {63'd0, done}, 64'd0);
    run_cycles(1, 1'b1);
    #1;
    chk("R8 done high at 32", {63'd0, done}, 64'd1);

    // Keep enabled past done: frozen, sticky (R6, R8, R4)
    run_cycles(10, 1'b1);
    #1;
    chk("R8 done held", {63'd0, done}, 64'd1);
    check_sig("R8 R6 R4 frozen signature", exp_full);

    // Out-of-range selects (R9)
    for (int s = 8; s < 256; s += 31) begin
      byte_sel = 8'(s);
      #1;
      chk("R9 out-of-range select", {56'd0, sig_byte}, 64'd0);
    end
    byte_sel = 8'd255;
    #1;
    chk("R9 select 255", {56'd0, sig_byte}, 64'd0);

    // Reset with enable high takes priority (R10)
    en = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    en = 1'b0;
    #1;
    chk("R10 reset over enable done", {63'd0, done}, 64'd0);
    check_sig("R10 reset over enable sig", 64'd0);

    // Rerun: same signature rebuilt (R1 seeds reloaded, R7)
    run_cycles(40, 1'b1);
    #1;
    chk("R1 rerun done", {63'd0, done}, 64'd1);
    check_sig("R1 R7 rerun signature", exp_full);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule